// File: doc/BRIEF.md
# Three-Channel Compare-Match Watchdog

This block holds three independent watchdog channels behind one 32-bit register port. Every channel has a tick counter that advances on each pulse of a reference tick enable, a limit register, and a small control register. Software keeps a channel alive by writing a new value, usually zero, into its counter. A channel whose reset request is armed expires once its counter is greater than or equal to its limit. When a channel expires it raises a reset request that stays high until the block itself is reset.

Expiry of channel 0 drives the recovery-mode reset line. Expiry of channels 1 and 2 drives the normal system reset line. Channel 0 also has a warning threshold. When its warning is enabled and the count reaches the threshold, a status bit sets and the interrupt line rises. Software clears that status by writing 1 to it.

The register port is a plain single-cycle interface. A write takes effect at the clock edge on which `wr_en` is high. Read data is a combinational function of `addr`. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `wdt_multi`

## Requirements
- R1: After `rst_n` is released, every counter reads 0 and every control register reads 0. Every limit register and the channel 0 warning register read 0xFFFFFFFF. `irq`, `recovery_rst` and `system_rst` are low.
- R2: Each channel c uses a block of 16 bytes at c*16. Offset 0x0 is the counter, 0x4 the limit, 0x8 the warning threshold (channel 0 only) and 0xC the control register. Every other offset is unmapped: it reads 0 and ignores writes. Examples are 0x18, 0x28, 0x30 and 0x3C.
- R3: A counter adds 1 on every clock edge where `tick` is high, and wraps from 0xFFFFFFFF to 0. A register write to the counter loads `wdata` and overrides the increment in the same cycle.
- R4: Suppose control bit 2 (reset enable) is set and count >= limit, both as held in the registers at a clock edge. The channel's request is then high after that edge. Channel 0 drives `recovery_rst`. Channels 1 and 2 drive `system_rst`.
- R5: A reset request, once raised, stays high until `rst_n` is asserted, even if reset enable is then cleared.
- R6: On channel 0, suppose control bit 0 (warning enable) is set and count >= warning threshold at a clock edge. Control bit 1 (warning status) then sets at that edge, and `irq` is high while bit 1 is set. With bit 0 clear, bit 1 never sets.
- R7: Writing control with bit 1 = 1 clears the warning status. Writing bit 1 = 0 leaves it unchanged. If the set condition also holds in that cycle, setting wins.
- R8: On channels 1 and 2, control bits 0 and 1 always read 0 and ignore writes. Only bit 2 is stored.
- R9: Writing 0 to a limit while the counter is 0 and reset enable is set produces the request on the edge right after the limit write.
- R10: With reset enable clear, a channel raises no request whatever its count. Its counter keeps advancing on `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the whole block |
| tick | input | 1 | Reference tick enable; every counter advances on edges where it is high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address of the register access |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Channel 0 warning interrupt |
| recovery_rst | output | 1 | Sticky recovery-mode reset request (channel 0) |
| system_rst | output | 1 | Sticky normal reset request (channels 1 and 2) |

## Verification
The bound checker watches several rules on every cycle:
- both reset lines stay high once raised;
- an armed channel whose count has reached its limit raises its line one edge later;
- the interrupt rises only after a cycle in which warning was enabled and the threshold was met;
- the channel 2 counter steps by exactly one on each unwritten tick.

Only the bench scenarios can show the rest:
- the register map and the unmapped holes;
- the masked control bits of channels 1 and 2;
- write-one-to-clear against write-zero;
- counter wrap and write priority;
- the exact edge on which the zero-limit request appears.

Random writes and tick bursts are compared against a bench model of every register.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // control register bit positions (software visible)
  localparam int CTL_WARN_EN   = 0;
  localparam int CTL_WARN_STAT = 1;
  localparam int CTL_ARM       = 2;
  localparam int CTL_W         = 3;

  // per-channel register window
  localparam int NUM_REGS      = 4;
  localparam int WIN_LOG2      = 4;

  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_LIMIT = 2'd1,
    REG_WARN  = 2'd2,
    REG_CTL   = 2'd3
  } wdt_reg_e;
endpackage

// File: rtl/wdt_decode.sv
module wdt_decode
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NUM_CH = 3,
  parameter logic [NUM_CH-1:0] WARN_MASK = '1
) (
  input  logic [ADDR_W-1:0]                   addr,
  input  logic                                wr_en,
  output logic                                hit,
  output logic [ADDR_W-WIN_LOG2-1:0]          ch_idx,
  output wdt_reg_e                            reg_sel,
  output logic [NUM_CH-1:0][NUM_REGS-1:0]     wr_vec
);
  localparam int CHF_W = ADDR_W - WIN_LOG2;

  logic aligned;
  logic ch_ok;
  logic warn_ok;

  assign ch_idx  = addr[ADDR_W-1:WIN_LOG2];
  assign reg_sel = wdt_reg_e'(addr[WIN_LOG2-1:2]);
  assign aligned = (addr[1:0] == 2'b00);
  assign ch_ok   = (int'(ch_idx) < NUM_CH);

  always_comb begin
    warn_ok = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_idx == CHF_W'(c)) warn_ok = WARN_MASK[c];
    end
  end

  assign hit = aligned && ch_ok && ((reg_sel != REG_WARN) || warn_ok);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      assign wr_vec[c][r] = wr_en && hit && (ch_idx == CHF_W'(c)) &&
                            (reg_sel == wdt_reg_e'(r));
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o
);
  // software load has priority over the tick increment; natural wrap
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_o <= '0;
    else if (load)   cnt_o <= load_val;
    else if (tick)   cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/wdt_channel.sv
module wdt_channel
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit HAS_WARN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic             wr_lim,
  input  logic             wr_warn,
  input  logic             wr_ctl,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o,
  output logic [CNT_W-1:0] warn_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             expire_o,
  output logic             irq_o
);
  logic arm_q;
  logic expire_q;

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (wr_cnt),
    .load_val (wdata),
    .cnt_o    (cnt_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      lim_o <= '1;
    else if (wr_lim) lim_o <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      arm_q <= 1'b0;
    else if (wr_ctl) arm_q <= wdata[CTL_ARM];
  end

  // sticky expiry request, cleared only by the block reset
  always_ff @(posedge clk) begin
    if (!rst_n)                          expire_q <= 1'b0;
    else if (arm_q && (cnt_o >= lim_o))  expire_q <= 1'b1;
  end
  assign expire_o = expire_q;

  if (HAS_WARN) begin : g_warn
    logic [CNT_W-1:0] warn_q;
    logic             wen_q;
    logic             wstat_q;
    logic             warn_hit;

    always_ff @(posedge clk) begin
      if (!rst_n)       warn_q <= '1;
      else if (wr_warn) warn_q <= wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)      wen_q <= 1'b0;
      else if (wr_ctl) wen_q <= wdata[CTL_WARN_EN];
    end

    assign warn_hit = wen_q && (cnt_o >= warn_q);

    // set wins over a write-one clear in the same cycle
    always_ff @(posedge clk) begin
      if (!rst_n)                               wstat_q <= 1'b0;
      else if (warn_hit)                        wstat_q <= 1'b1;
      else if (wr_ctl && wdata[CTL_WARN_STAT])  wstat_q <= 1'b0;
    end

    assign warn_o = warn_q;
    assign irq_o  = wstat_q;
    assign ctl_o  = {arm_q, wstat_q, wen_q};
  end else begin : g_nowarn
    logic unused_warn_wr;
    assign unused_warn_wr = wr_warn;
    assign warn_o = '0;
    assign irq_o  = 1'b0;
    assign ctl_o  = {arm_q, 2'b00};
  end
endmodule

// File: rtl/wdt_multi.sv
module wdt_multi
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 3,
  parameter logic [NUM_CH-1:0] WARN_MASK  = 3'b001,
  parameter logic [NUM_CH-1:0] RECOV_MASK = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq,
  output logic              recovery_rst,
  output logic              system_rst
);
  localparam int CHF_W = ADDR_W - WIN_LOG2;

  logic                               hit;
  logic [CHF_W-1:0]                   ch_idx;
  wdt_reg_e                           reg_sel;
  logic [NUM_CH-1:0][NUM_REGS-1:0]    wr_vec;

  logic [NUM_CH-1:0][CNT_W-1:0]       cnt_q;
  logic [NUM_CH-1:0][CNT_W-1:0]       lim_q;
  logic [NUM_CH-1:0][CNT_W-1:0]       warn_q;
  logic [NUM_CH-1:0][CTL_W-1:0]       ctl_q;
  logic [NUM_CH-1:0]                  expire;
  logic [NUM_CH-1:0]                  irq_vec;

  wdt_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_CH    (NUM_CH),
    .WARN_MASK (WARN_MASK)
  ) u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .hit     (hit),
    .ch_idx  (ch_idx),
    .reg_sel (reg_sel),
    .wr_vec  (wr_vec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    wdt_channel #(
      .CNT_W    (CNT_W),
      .HAS_WARN (WARN_MASK[c])
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .wr_cnt   (wr_vec[c][REG_COUNT]),
      .wr_lim   (wr_vec[c][REG_LIMIT]),
      .wr_warn  (wr_vec[c][REG_WARN]),
      .wr_ctl   (wr_vec[c][REG_CTL]),
      .wdata    (wdata),
      .cnt_o    (cnt_q[c]),
      .lim_o    (lim_q[c]),
      .warn_o   (warn_q[c]),
      .ctl_o    (ctl_q[c]),
      .expire_o (expire[c]),
      .irq_o    (irq_vec[c])
    );
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit && (ch_idx == CHF_W'(c))) begin
        unique case (reg_sel)
          REG_COUNT: rdata = cnt_q[c];
          REG_LIMIT: rdata = lim_q[c];
          REG_WARN:  rdata = warn_q[c];
          REG_CTL:   rdata = CNT_W'(ctl_q[c]);
          default:   rdata = '0;
        endcase
      end
    end
  end

  assign irq          = |irq_vec;
  assign recovery_rst = |(expire & RECOV_MASK);
  assign system_rst   = |(expire & ~RECOV_MASK);
endmodule

// File: rtl/wdt_multi_chk.sv
module wdt_multi_chk
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tick,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             addr,
  input logic                          irq,
  input logic                          recovery_rst,
  input logic                          system_rst,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_q,
  input logic [NUM_CH-1:0][CNT_W-1:0]  lim_q,
  input logic [NUM_CH-1:0][CNT_W-1:0]  warn_q,
  input logic [NUM_CH-1:0][CTL_W-1:0]  ctl_q
);
  localparam logic [ADDR_W-1:0] CH2_CNT_ADDR = ADDR_W'(2 << WIN_LOG2);

  // R5: requests are sticky
  a_r5_recov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_rst |=> recovery_rst);
  a_r5_sys_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    system_rst |=> system_rst);

  // R4: armed channel at or past its limit raises its line next edge
  a_r4_ch0_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0][CTL_ARM] && (cnt_q[0] >= lim_q[0])) |=> recovery_rst);
  a_r4_ch1_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[1][CTL_ARM] && (cnt_q[1] >= lim_q[1])) |=> system_rst);

  // R6: warning sets the interrupt, and only with a cause
  a_r6_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0][CTL_WARN_EN] && (cnt_q[0] >= warn_q[0])) |=> irq);
  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctl_q[0][CTL_WARN_EN] && (cnt_q[0] >= warn_q[0])));

  // R3: unwritten tick advances the counter by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(wr_en && (addr == CH2_CNT_ADDR))) |=>
      (cnt_q[2] == $past(cnt_q[2]) + CNT_W'(1)));
endmodule

bind wdt_multi wdt_multi_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .NUM_CH (NUM_CH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .wr_en        (wr_en),
  .addr         (addr),
  .irq          (irq),
  .recovery_rst (recovery_rst),
  .system_rst   (system_rst),
  .cnt_q        (cnt_q),
  .lim_q        (lim_q),
  .warn_q       (warn_q),
  .ctl_q        (ctl_q)
);

// File: tb/wdt_multi_bench.sv
module wdt_multi_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, recovery_rst, system_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_cnt [3];
  logic [31:0] m_lim [3];
  logic [31:0] m_warn;

  always #2 clk = ~clk;

  wdt_multi u_wdt_multi (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq),
    .recovery_rst(recovery_rst), .system_rst(system_rst)
  );

  function automatic logic [5:0] reg_addr(int ch, int r);
    return 6'(ch * 16 + r * 4);
  endfunction

  function automatic logic [31:0] exp_ctl(int ch, logic [31:0] v);
    return (ch == 0) ? (v & 32'h1) : (v & 32'h4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic tick_n(int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 3; c++) begin m_cnt[c] = '0; m_lim[c] = '1; end
    m_warn = '1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    do_reset();

    // R1 reset values
    for (int c = 0; c < 3; c++) begin
      rd(reg_addr(c, 0), d); chk("R1 count", d, 32'h0);
      rd(reg_addr(c, 1), d); chk("R1 limit", d, 32'hFFFF_FFFF);
      rd(reg_addr(c, 3), d); chk("R1 ctl", d, 32'h0);
    end
    rd(reg_addr(0, 2), d); chk("R1 warn", d, 32'hFFFF_FFFF);
    chk("R1 outputs", {29'b0, irq, recovery_rst, system_rst}, 32'h0);

    // R2 unmapped holes
    wr(6'h18, 32'h1234_5678);
    rd(6'h18, d); chk("R2 0x18", d, 32'h0);
    rd(6'h28, d); chk("R2 0x28", d, 32'h0);
    rd(6'h30, d); chk("R2 0x30", d, 32'h0);
    rd(6'h3C, d); chk("R2 0x3C", d, 32'h0);
    rd(6'h05, d); chk("R2 misaligned", d, 32'h0);

    // random register traffic and tick bursts against the model (R2, R3)
    for (int i = 0; i < 60; i++) begin
      int ch = int'($urandom % 3);
      int r  = int'($urandom % 3);
      logic [31:0] v = $urandom;
      if (r == 2 && ch != 0) r = 1;
      wr(reg_addr(ch, r), v);
      if (r == 0) m_cnt[ch] = v; else if (r == 1) m_lim[ch] = v; else m_warn = v;
      rd(reg_addr(ch, r), d); chk("R2 random readback", d, v);
      if (i % 6 == 5) begin
        int n = 1 + int'($urandom % 20);
        tick_n(n);
        for (int c = 0; c < 3; c++) begin
          m_cnt[c] = m_cnt[c] + 32'(n);
          rd(reg_addr(c, 0), d); chk("R3 tick burst", d, m_cnt[c]);
        end
      end
    end
    rd(reg_addr(0, 2), d); chk("R2 warn model", d, m_warn);
    chk("R10 no request while disarmed", {30'b0, recovery_rst, system_rst}, 32'h0);

    // R3 wrap and write priority
    do_reset();
    wr(reg_addr(0, 0), 32'hFFFF_FFFE);
    tick_n(3);
    rd(reg_addr(0, 0), d); chk("R3 wrap", d, 32'h1);
    @(negedge clk); tick = 1'b1;
    wr(reg_addr(1, 0), 32'd100);
    #1 chk("R3 write over tick", rdata, 32'd100);
    @(negedge clk); #1 chk("R3 resume after write", rdata, 32'd101);
    tick = 1'b0;

    // R8 masked control bits on channels 1 and 2
    wr(reg_addr(1, 3), 32'h3);
    rd(reg_addr(1, 3), d); chk("R8 ch1 ctl", d, exp_ctl(1, 32'h3));
    wr(reg_addr(2, 3), 32'h3);
    rd(reg_addr(2, 3), d); chk("R8 ch2 ctl", d, exp_ctl(2, 32'h3));
    chk("R8 no irq", {31'b0, irq}, 32'h0);

    // R9 zero limit with zero count
    do_reset();
    wr(reg_addr(1, 0), 32'h0);
    wr(reg_addr(1, 3), 32'h4);
    chk("R9 quiet before limit write", {31'b0, system_rst}, 32'h0);
    wr(reg_addr(1, 1), 32'h0);
    chk("R9 not yet", {31'b0, system_rst}, 32'h0);
    @(negedge clk);
    chk("R9 fires next edge", {31'b0, system_rst}, 32'h1);
    chk("R4 channel 1 not recovery", {31'b0, recovery_rst}, 32'h0);

    // R5 sticky after disarm
    wr(reg_addr(1, 3), 32'h0);
    repeat (3) @(negedge clk);
    chk("R5 sticky", {31'b0, system_rst}, 32'h1);
    do_reset();
    chk("R5 cleared by reset", {31'b0, system_rst}, 32'h0);

    // R4 channel 2 counts up to its limit
    wr(reg_addr(2, 1), 32'd10);
    wr(reg_addr(2, 0), 32'd5);
    wr(reg_addr(2, 3), 32'h4);
    tick_n(5);
    chk("R4 before compare", {31'b0, system_rst}, 32'h0);
    @(negedge clk);
    chk("R4 ch2 fires", {31'b0, system_rst}, 32'h1);
    chk("R4 ch2 not recovery", {31'b0, recovery_rst}, 32'h0);

    // R4 channel 0 -> recovery line
    do_reset();
    wr(reg_addr(0, 1), 32'd2);
    wr(reg_addr(0, 3), 32'h4);
    tick_n(2);
    @(negedge clk);
    chk("R4 ch0 recovery", {30'b0, recovery_rst, system_rst}, 32'h2);

    // R10 disarm before limit, counting continues
    do_reset();
    wr(reg_addr(1, 1), 32'd20);
    wr(reg_addr(1, 3), 32'h4);
    tick_n(5);
    wr(reg_addr(1, 3), 32'h0);
    tick_n(40);
    chk("R10 no request", {31'b0, system_rst}, 32'h0);
    rd(reg_addr(1, 0), d); chk("R10 counter runs", d, 32'd45);

    // R6 warning interrupt
    do_reset();
    wr(reg_addr(0, 2), 32'd3);
    wr(reg_addr(0, 3), 32'h0);
    repeat (3) @(negedge clk);
    wr(reg_addr(0, 0), 32'd10);
    repeat (2) @(negedge clk);
    chk("R6 no irq while disabled", {31'b0, irq}, 32'h0);
    wr(reg_addr(0, 0), 32'd0);
    wr(reg_addr(0, 3), 32'h1);
    tick_n(3);
    chk("R6 irq before edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R6 irq set", {31'b0, irq}, 32'h1);
    rd(reg_addr(0, 3), d); chk("R6 status bit", d, 32'h3);

    // R7 write-one-to-clear
    wr(reg_addr(0, 2), 32'hFFFF_FFFF);
    wr(reg_addr(0, 3), 32'h1);
    rd(reg_addr(0, 3), d); chk("R7 write zero keeps", d, 32'h3);
    chk("R7 irq kept", {31'b0, irq}, 32'h1);
    wr(reg_addr(0, 3), 32'h3);
    rd(reg_addr(0, 3), d); chk("R7 write one clears", d, 32'h1);
    chk("R7 irq cleared", {31'b0, irq}, 32'h0);
    wr(reg_addr(0, 2), 32'h0);
    wr(reg_addr(0, 3), 32'h3);
    rd(reg_addr(0, 3), d); chk("R7 set wins", d, 32'h3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule